// File: doc/BRIEF.md
# Breakpoint Value Register Access Trap Arbiter

This block sits beside a processor's system-register access path. It decides what happens when a coprocessor-style read or write targets one of the breakpoint value registers. Each request carries:

- the decoded instruction fields, and
- the current privilege level, plus a snapshot of the controls that govern debug-register access: halted state, presence and register width of the two higher privilege levels, their debug trap-enable bits, the secure-debug-disable flag, the OS lock, the halting-allowed condition and the external trap-on-access bit.

One clock after an accepted request, the block presents a one-hot outcome and holds it. The outcome is one of: undefined, trap to level 2 in 64-bit state, hypervisor trap in 32-bit state, trap to level 3, debug halt, or perform the access. A syndrome class and the breakpoint index come with it. When the outcome is to perform the access, a one-cycle read or write strobe is raised, and the register file uses it. Delivering the exception itself is left to other logic.

The checks form a fixed priority chain that depends on privilege. Level 0 is always refused. Level 1 runs the full chain. Level 2 skips the level-2 trap checks. Level 3 only considers the debug halt. A build-time option chooses whether a halted core with secure debug disabled and a level-3 trap enabled is refused before any level-2 trap is considered.

Top module: `bvr_trap_arbiter`

## Requirements
- R1: A request is accepted only when `req_valid` is high and `req_coproc`=4'b1110, `req_opc1`=3'b000, `req_crn`=4'b0000 and `req_opc2`=3'b100. An accepted request raises `rsp_valid` for exactly the following cycle. A request that does not match raises neither `rsp_valid` nor a strobe, and leaves the held response unchanged.
- R2: At privilege level 0 the outcome is always undefined (`rsp_outcome` bit 0).
- R3: At level 1, when no earlier check holds, level 2 enabled in 64-bit state with either level-2 trap bit set gives trap to level 2 (bit 1).
- R4: At level 1, when no earlier check holds, level 2 enabled in 32-bit state with either level-2 trap bit set gives the hypervisor trap (bit 2).
- R5: At levels 1 and 2, when no earlier check holds, level 3 present in 64-bit state with its trap bit set gives undefined if the core is halted with secure debug disabled. Otherwise it gives trap to level 3 (bit 3).
- R6: With parameter `SDD_UNDEF_FIRST`=1 (the default), the following gives undefined at levels 1 and 2, ahead of every other check: halted, secure debug disabled, and level 3 present in 64-bit state with its trap bit set.
- R7: At level 2 the level-2 trap bits have no effect on the outcome.
- R8: At level 3 only the debug-halt check applies. The outcome is debug halt or perform access, whatever the trap and secure-debug controls say.
- R9: Debug halt (bit 4) is chosen when the OS lock is clear, halting is allowed and the external trap-on-access bit is set, provided no earlier check holds.
- R10: Perform access (bit 5) pulses `acc_rd_stb` or `acc_wr_stb` for the response cycle, chosen by `req_write`. `rsp_index` is CRm and `rsp_write` is the direction.
- R11: `rsp_class` is 6'h05 for the three trap outcomes (bits 1, 2, 3) and 0 for the other outcomes.
- R12: Exactly one outcome bit is set whenever `rsp_valid` is high. After reset the outcome, class, index and strobes are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_coproc | input | 4 | Coprocessor number field |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | IDX_W | Breakpoint index field |
| req_opc2 | input | 3 | Second opcode field |
| cur_priv | input | 2 | Current privilege level 0..3 |
| halted | input | 1 | Core is in debug halt state |
| l2_enabled | input | 1 | Level 2 enabled in current security state |
| l2_is64 | input | 1 | Level 2 runs in 64-bit state |
| l2_trap_de | input | 1 | Level-2 debug exception routing trap bit |
| l2_trap_da | input | 1 | Level-2 debug register access trap bit |
| l3_present | input | 1 | Level 3 implemented |
| l3_is64 | input | 1 | Level 3 runs in 64-bit state |
| l3_trap_da | input | 1 | Level-3 debug register access trap bit |
| sec_dbg_off | input | 1 | Secure debug disabled |
| os_lock | input | 1 | OS lock set |
| halt_allowed | input | 1 | Halting currently permitted |
| ext_trap_da | input | 1 | External debugger trap-on-access bit |
| rsp_valid | output | 1 | One-cycle pulse: new response |
| rsp_outcome | output | 6 | One-hot outcome, held |
| rsp_class | output | EC_W | Syndrome class, held |
| rsp_index | output | IDX_W | Breakpoint index, held |
| rsp_write | output | 1 | Direction of the held response |
| acc_rd_stb | output | 1 | Perform read, one cycle |
| acc_wr_stb | output | 1 | Perform write, one cycle |

## Verification
The bench targets requests in which several checks hold at once. A design with a wrong priority order would report a level-2 trap where the level-3 refusal or the early undefined case must win. It also drives privilege levels 2 and 3 with every trap bit set. A design that did not strip the level-2 or level-3 checks there would trap when it should halt or perform the access. Requests with one opcode field off by a bit are mixed in. A loose decoder would raise a response or a strobe for them, or disturb the held outcome. Class and strobe values are compared on every response, which catches a class reported on undefined or halt outcomes and a strobe of the wrong direction.

// File: rtl/bvr_trap_pkg.sv
package bvr_trap_pkg;
  localparam int OC_W      = 6;
  localparam int OC_UNDEF  = 0;
  localparam int OC_TRAP2  = 1;
  localparam int OC_HYP    = 2;
  localparam int OC_TRAP3  = 3;
  localparam int OC_HALT   = 4;
  localparam int OC_ACCESS = 5;

  typedef logic [OC_W-1:0] outcome_t;

  typedef struct packed {
    logic halted;
    logic l2_enabled;
    logic l2_is64;
    logic l2_trap_de;
    logic l2_trap_da;
    logic l3_present;
    logic l3_is64;
    logic l3_trap_da;
    logic sec_dbg_off;
    logic os_lock;
    logic halt_allowed;
    logic ext_trap_da;
  } dbg_ctl_t;
endpackage

// File: rtl/bvr_sel_decode.sv
module bvr_sel_decode #(
  parameter logic [3:0] SEL_COPROC = 4'b1110,
  parameter logic [2:0] SEL_OPC1   = 3'b000,
  parameter logic [3:0] SEL_CRN    = 4'b0000,
  parameter logic [2:0] SEL_OPC2   = 3'b100
) (
  input  logic [3:0] coproc,
  input  logic [2:0] opc1,
  input  logic [3:0] crn,
  input  logic [2:0] opc2,
  output logic       hit
);
  always_comb begin
    hit = (coproc == SEL_COPROC) && (opc1 == SEL_OPC1) &&
          (crn == SEL_CRN) && (opc2 == SEL_OPC2);
  end
endmodule

// File: rtl/bvr_trap_chain.sv
module bvr_trap_chain
  import bvr_trap_pkg::*;
#(
  parameter bit SDD_UNDEF_FIRST = 1'b1
) (
  input  logic [1:0] priv,
  input  dbg_ctl_t   ctl,
  output outcome_t   outcome
);
  logic l3_trap, l2_any, halt_hit, sdd_halted, early_undef;

  always_comb begin
    l3_trap    = ctl.l3_present && ctl.l3_is64 && ctl.l3_trap_da;
    l2_any     = ctl.l2_trap_de || ctl.l2_trap_da;
    halt_hit   = !ctl.os_lock && ctl.halt_allowed && ctl.ext_trap_da;
    sdd_halted = ctl.halted && ctl.sec_dbg_off;
  end

  generate
    if (SDD_UNDEF_FIRST) begin : g_early
      assign early_undef = sdd_halted && l3_trap;
    end else begin : g_late
      assign early_undef = 1'b0;
    end
  endgenerate

  always_comb begin
    outcome = '0;
    unique case (priv)
      2'd0: outcome[OC_UNDEF] = 1'b1;
      2'd1: begin
        if (early_undef)                                  outcome[OC_UNDEF]  = 1'b1;
        else if (ctl.l2_enabled && ctl.l2_is64 && l2_any)  outcome[OC_TRAP2]  = 1'b1;
        else if (ctl.l2_enabled && !ctl.l2_is64 && l2_any) outcome[OC_HYP]    = 1'b1;
        else if (l3_trap && sdd_halted)                    outcome[OC_UNDEF]  = 1'b1;
        else if (l3_trap)                                  outcome[OC_TRAP3]  = 1'b1;
        else if (halt_hit)                                 outcome[OC_HALT]   = 1'b1;
        else                                               outcome[OC_ACCESS] = 1'b1;
      end
      2'd2: begin
        if (early_undef)                 outcome[OC_UNDEF]  = 1'b1;
        else if (l3_trap && sdd_halted)  outcome[OC_UNDEF]  = 1'b1;
        else if (l3_trap)                outcome[OC_TRAP3]  = 1'b1;
        else if (halt_hit)               outcome[OC_HALT]   = 1'b1;
        else                             outcome[OC_ACCESS] = 1'b1;
      end
      default: begin
        if (halt_hit) outcome[OC_HALT]   = 1'b1;
        else          outcome[OC_ACCESS] = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/bvr_outcome_reg.sv
module bvr_outcome_reg
  import bvr_trap_pkg::*;
#(
  parameter int          IDX_W    = 4,
  parameter int          EC_W     = 6,
  parameter logic [EC_W-1:0] TRAP_EC = 'h05
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             is_write,
  input  logic [IDX_W-1:0] index,
  input  outcome_t         outcome_d,
  output logic             rsp_valid,
  output outcome_t         rsp_outcome,
  output logic [EC_W-1:0]  rsp_class,
  output logic [IDX_W-1:0] rsp_index,
  output logic             rsp_write,
  output logic             acc_rd_stb,
  output logic             acc_wr_stb
);
  logic is_trap;

  always_comb begin
    is_trap = outcome_d[OC_TRAP2] || outcome_d[OC_HYP] || outcome_d[OC_TRAP3];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_outcome <= '0;
      rsp_class   <= '0;
      rsp_index   <= '0;
      rsp_write   <= 1'b0;
      acc_rd_stb  <= 1'b0;
      acc_wr_stb  <= 1'b0;
    end else begin
      rsp_valid  <= take;
      acc_rd_stb <= take && outcome_d[OC_ACCESS] && !is_write;
      acc_wr_stb <= take && outcome_d[OC_ACCESS] && is_write;
      if (take) begin
        rsp_outcome <= outcome_d;
        rsp_class   <= is_trap ? TRAP_EC : '0;
        rsp_index   <= index;
        rsp_write   <= is_write;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    take |=> rsp_valid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
    !take |=> !rsp_valid && !acc_rd_stb && !acc_wr_stb);
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(rsp_outcome) && $stable(rsp_index) && $stable(rsp_class));
  p_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones(rsp_outcome) == 1);
  p_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    (acc_rd_stb || acc_wr_stb) |-> rsp_valid && rsp_outcome[OC_ACCESS] && (acc_wr_stb == rsp_write));
  p_class_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && (rsp_outcome[OC_UNDEF] || rsp_outcome[OC_HALT] || rsp_outcome[OC_ACCESS])
      |-> rsp_class == '0);
endmodule

// File: rtl/bvr_trap_arbiter.sv
module bvr_trap_arbiter
  import bvr_trap_pkg::*;
#(
  parameter int IDX_W           = 4,
  parameter int EC_W            = 6,
  parameter bit SDD_UNDEF_FIRST = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [3:0]       req_coproc,
  input  logic [2:0]       req_opc1,
  input  logic [3:0]       req_crn,
  input  logic [IDX_W-1:0] req_crm,
  input  logic [2:0]       req_opc2,
  input  logic [1:0]       cur_priv,
  input  logic             halted,
  input  logic             l2_enabled,
  input  logic             l2_is64,
  input  logic             l2_trap_de,
  input  logic             l2_trap_da,
  input  logic             l3_present,
  input  logic             l3_is64,
  input  logic             l3_trap_da,
  input  logic             sec_dbg_off,
  input  logic             os_lock,
  input  logic             halt_allowed,
  input  logic             ext_trap_da,
  output logic             rsp_valid,
  output logic [5:0]       rsp_outcome,
  output logic [EC_W-1:0]  rsp_class,
  output logic [IDX_W-1:0] rsp_index,
  output logic             rsp_write,
  output logic             acc_rd_stb,
  output logic             acc_wr_stb
);
  logic     sel_hit, take;
  dbg_ctl_t ctl;
  outcome_t chain_out;

  always_comb begin
    ctl.halted       = halted;
    ctl.l2_enabled   = l2_enabled;
    ctl.l2_is64      = l2_is64;
    ctl.l2_trap_de   = l2_trap_de;
    ctl.l2_trap_da   = l2_trap_da;
    ctl.l3_present   = l3_present;
    ctl.l3_is64      = l3_is64;
    ctl.l3_trap_da   = l3_trap_da;
    ctl.sec_dbg_off  = sec_dbg_off;
    ctl.os_lock      = os_lock;
    ctl.halt_allowed = halt_allowed;
    ctl.ext_trap_da  = ext_trap_da;
    take             = req_valid && sel_hit;
  end

  bvr_sel_decode u_decode (
    .coproc (req_coproc),
    .opc1   (req_opc1),
    .crn    (req_crn),
    .opc2   (req_opc2),
    .hit    (sel_hit)
  );

  bvr_trap_chain #(.SDD_UNDEF_FIRST(SDD_UNDEF_FIRST)) u_chain (
    .priv    (cur_priv),
    .ctl     (ctl),
    .outcome (chain_out)
  );

  bvr_outcome_reg #(.IDX_W(IDX_W), .EC_W(EC_W)) u_oreg (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .is_write    (req_write),
    .index       (req_crm),
    .outcome_d   (chain_out),
    .rsp_valid   (rsp_valid),
    .rsp_outcome (rsp_outcome),
    .rsp_class   (rsp_class),
    .rsp_index   (rsp_index),
    .rsp_write   (rsp_write),
    .acc_rd_stb  (acc_rd_stb),
    .acc_wr_stb  (acc_wr_stb)
  );

  p_priv0_undef_r2: assert property (@(posedge clk) disable iff (rst)
    take && cur_priv == 2'd0 |=> rsp_outcome[OC_UNDEF]);
  p_priv3_only_halt_r8: assert property (@(posedge clk) disable iff (rst)
    take && cur_priv == 2'd3 |=> rsp_outcome[OC_HALT] || rsp_outcome[OC_ACCESS]);
  p_priv2_no_l2_r7: assert property (@(posedge clk) disable iff (rst)
    take && cur_priv == 2'd2 |=> !rsp_outcome[OC_TRAP2] && !rsp_outcome[OC_HYP]);
  p_index_r10: assert property (@(posedge clk) disable iff (rst)
    take |=> rsp_index == $past(req_crm) && rsp_write == $past(req_write));
endmodule

// File: tb/test_bvr_trap_arbiter.sv
module test_bvr_trap_arbiter;
  localparam int IDX_W = 4;
  localparam int EC_W  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [3:0] req_coproc = 0, req_crn = 0;
  logic [2:0] req_opc1 = 0, req_opc2 = 0;
  logic [IDX_W-1:0] req_crm = 0;
  logic [1:0] cur_priv = 0;
  logic halted = 0, l2_enabled = 0, l2_is64 = 0, l2_trap_de = 0, l2_trap_da = 0;
  logic l3_present = 0, l3_is64 = 0, l3_trap_da = 0, sec_dbg_off = 0;
  logic os_lock = 0, halt_allowed = 0, ext_trap_da = 0;
  logic rsp_valid, rsp_write, acc_rd_stb, acc_wr_stb;
  logic [5:0] rsp_outcome;
  logic [EC_W-1:0] rsp_class;
  logic [IDX_W-1:0] rsp_index;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [5:0] held_out = 0;
  logic [IDX_W-1:0] held_idx = 0;

  always #10 clk = ~clk;

  bvr_trap_arbiter #(.IDX_W(IDX_W), .EC_W(EC_W)) i_bvr_trap_arbiter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_coproc(req_coproc), .req_opc1(req_opc1), .req_crn(req_crn),
    .req_crm(req_crm), .req_opc2(req_opc2), .cur_priv(cur_priv),
    .halted(halted), .l2_enabled(l2_enabled), .l2_is64(l2_is64),
    .l2_trap_de(l2_trap_de), .l2_trap_da(l2_trap_da), .l3_present(l3_present),
    .l3_is64(l3_is64), .l3_trap_da(l3_trap_da), .sec_dbg_off(sec_dbg_off),
    .os_lock(os_lock), .halt_allowed(halt_allowed), .ext_trap_da(ext_trap_da),
    .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome), .rsp_class(rsp_class),
    .rsp_index(rsp_index), .rsp_write(rsp_write),
    .acc_rd_stb(acc_rd_stb), .acc_wr_stb(acc_wr_stb));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Reference priority order written from the requirements (default option on)
  function automatic logic [5:0] ref_out();
    logic l3t, sddh, l2t;
    l3t  = l3_present && l3_is64 && l3_trap_da;
    sddh = halted && sec_dbg_off;
    l2t  = l2_trap_de || l2_trap_da;
    if (cur_priv == 2'd0) return 6'b000001;
    if (cur_priv != 2'd3) begin
      if (l3t && sddh) return 6'b000001;
      if (cur_priv == 2'd1 && l2_enabled && l2t) return l2_is64 ? 6'b000010 : 6'b000100;
      if (l3t) return 6'b001000;
    end
    if (!os_lock && halt_allowed && ext_trap_da) return 6'b010000;
    return 6'b100000;
  endfunction

  function automatic string tag_of(logic [5:0] o);
    if (cur_priv == 2'd0) return "R2";
    if (cur_priv == 2'd3) return "R8";
    case (o)
      6'b000010: return "R3";
      6'b000100: return "R4";
      6'b001000: return "R5";
      6'b010000: return "R9";
      6'b100000: return "R10";
      default:   return "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_sel(input bit good);
    req_coproc = 4'b1110; req_opc1 = 3'b000; req_crn = 4'b0000; req_opc2 = 3'b100;
    if (!good) begin
      case ($urandom_range(0, 3))
        0: req_coproc[$urandom_range(0, 3)] ^= 1'b1;
        1: req_opc1[$urandom_range(0, 2)] ^= 1'b1;
        2: req_crn[$urandom_range(0, 3)] ^= 1'b1;
        default: req_opc2[$urandom_range(0, 2)] ^= 1'b1;
      endcase
    end
  endtask

  task automatic rand_ctl();
    logic [11:0] r;
    r = 12'($urandom);
    {halted, l2_enabled, l2_is64, l2_trap_de, l2_trap_da, l3_present,
     l3_is64, l3_trap_da, sec_dbg_off, os_lock, halt_allowed, ext_trap_da} = r;
  endtask

  // Drive at a falling edge; response checked at the next falling edge
  task automatic request(input bit good);
    logic [5:0] e;
    logic [EC_W-1:0] ec;
    string t;
    set_sel(good);
    req_valid = 1'b1;
    e  = ref_out();
    t  = tag_of(e);
    ec = (e[1] || e[2] || e[3]) ? 6'h05 : 6'h00;
    @(negedge clk);
    req_valid = 1'b0;
    if (good) begin
      chk(rsp_valid === 1'b1, "R1", 32'(rsp_valid), 1);
      chk(rsp_outcome === e, t, 32'(rsp_outcome), 32'(e));
      chk(rsp_class === ec, "R11", 32'(rsp_class), 32'(ec));
      chk(rsp_index === req_crm && rsp_write === req_write, "R10",
          {rsp_write, 27'd0, rsp_index}, {req_write, 27'd0, req_crm});
      chk(acc_rd_stb === (e[5] && !req_write) && acc_wr_stb === (e[5] && req_write),
          "R10", {acc_wr_stb, acc_rd_stb}, {e[5] && req_write, e[5] && !req_write});
      held_out = e;
      held_idx = req_crm;
    end else begin
      chk(!rsp_valid && !acc_rd_stb && !acc_wr_stb, "R1",
          {rsp_valid, acc_wr_stb, acc_rd_stb}, 0);
      chk(rsp_outcome === held_out && rsp_index === held_idx, "R1",
          {rsp_outcome, rsp_index}, {held_out, held_idx});
    end
  endtask

  task automatic clear_ctl();
    {halted, l2_enabled, l2_is64, l2_trap_de, l2_trap_da, l3_present,
     l3_is64, l3_trap_da, sec_dbg_off, os_lock, halt_allowed, ext_trap_da} = '0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(rsp_outcome === 0 && rsp_class === 0 && !rsp_valid && !acc_rd_stb && !acc_wr_stb
        && rsp_index === 0, "R12", {rsp_valid, rsp_outcome, rsp_class}, 0);

    // R2: level 0 with everything permissive
    clear_ctl(); cur_priv = 0; req_crm = 4'd3; request(1'b1);
    // R3 beats R4/R5: level 1, level 2 64-bit trap, level 3 trap also set
    clear_ctl(); cur_priv = 1; l2_enabled = 1; l2_is64 = 1; l2_trap_da = 1;
    l3_present = 1; l3_is64 = 1; l3_trap_da = 1; request(1'b1);
    // R4: 32-bit hypervisor trap via the other bit
    clear_ctl(); cur_priv = 1; l2_enabled = 1; l2_trap_de = 1; request(1'b1);
    // R6: early undefined wins over the level-2 trap
    clear_ctl(); cur_priv = 1; l2_enabled = 1; l2_is64 = 1; l2_trap_de = 1;
    halted = 1; sec_dbg_off = 1; l3_present = 1; l3_is64 = 1; l3_trap_da = 1;
    request(1'b1);
    // R5: trap to level 3 when not halted
    clear_ctl(); cur_priv = 1; l3_present = 1; l3_is64 = 1; l3_trap_da = 1;
    ext_trap_da = 1; halt_allowed = 1; request(1'b1);
    // R5: level 3 in 32-bit state does not trap -> R9 halt
    clear_ctl(); cur_priv = 1; l3_present = 1; l3_trap_da = 1;
    ext_trap_da = 1; halt_allowed = 1; request(1'b1);
    // R7: level 2 ignores level-2 trap bits -> access write, index 15
    clear_ctl(); cur_priv = 2; l2_enabled = 1; l2_is64 = 1; l2_trap_de = 1; l2_trap_da = 1;
    req_write = 1; req_crm = 4'd15; request(1'b1);
    // R8: level 3 with every trap set, halt blocked by OS lock -> access read
    clear_ctl(); cur_priv = 3; l2_enabled = 1; l2_trap_da = 1; halted = 1; sec_dbg_off = 1;
    l3_present = 1; l3_is64 = 1; l3_trap_da = 1; os_lock = 1; ext_trap_da = 1; halt_allowed = 1;
    req_write = 0; req_crm = 4'd0; request(1'b1);
    // R9: level 3 halt
    os_lock = 0; request(1'b1);
    // R1: mismatching fields ignored; idle cycle shows pulse and hold
    request(1'b0);
    @(negedge clk);
    chk(!rsp_valid && rsp_outcome === held_out, "R12", {rsp_valid, rsp_outcome}, {1'b0, held_out});

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      rand_ctl();
      cur_priv  = 2'($urandom_range(0, 3));
      req_crm   = IDX_W'($urandom);
      req_write = 1'($urandom);
      request($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 7) == 0) @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule